// File: doc/BRIEF.md
# Four-Source Masked Priority Interrupt Controller

This block collects interrupt requests from four devices and turns them into one CPU interrupt line and a vector that identifies the device to serve. Each request line passes through a two-flop synchroniser. A rising edge on it sets a pending bit. That bit stays set until software clears it by writing a 1 to it. The pending bits are gated by a mask register. A fixed-priority encoder then picks the lowest-numbered unmasked pending source.

A status flop registers whether any unmasked request exists. The CPU interrupt line is the AND of that status flop and an enable flop that software controls. When the CPU acknowledges, the block drives a vector made of a programmable 6-bit base followed by the 2-bit winner index. It also clears the enable flop, so the handler has to re-enable interrupts on purpose.

The vector is presented on a data output with an output-enable. The output-enable drives a tri-state pad, which keeps the bus released outside acknowledge. Software reaches four byte-wide write registers through a simple write strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_drive` are 0, `vec_out` is 0, every pending bit is clear, the mask is 0 (all sources blocked), and the enable is 0.
- R2: A pending bit is set only by a rising edge of its request line, seen after two synchroniser flops. A request line held high does not set the bit again after a software clear.
- R3: Writing address 1 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value. No other action clears a pending bit.
- R4: Writing address 0 loads the mask from `reg_wdata[3:0]`. Bit i = 1 lets source i take part, and bit i = 0 blocks it from `int_out` and from the vector.
- R5: Among unmasked pending sources, source 0 has the highest priority and source 3 the lowest. The winner index appears as `vec_out[1:0]`.
- R6: A status flop takes the OR of the unmasked pending bits one clock later. `int_out` is high exactly when that flop and the enable are both 1.
- R7: Writing address 3 loads the vector base from `reg_wdata[5:0]`. While `int_ack` is high, `vec_drive` is 1 and `vec_out` = {base, winner index}. While `int_ack` is low, `vec_drive` is 0 and `vec_out` is 0.
- R8: Writing address 2 loads the enable from `reg_wdata[0]`. An acknowledge clears the enable at the next clock edge, and it wins over an enable write in the same cycle.
- R9: When a rising edge sets a pending bit in the same cycle that a clear write targets that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 4 | Device request lines, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 clear, 2 enable, 3 base |
| reg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | CPU interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector address |
| vec_drive | output | 1 | Output-enable for the vector bus pads |

## Verification
The pending bits, mask, enable, status flop and base can only be seen through `int_out` and through the vector given out on acknowledge. Checks therefore pair each state change with a later acknowledge, or with an observation of `int_out`.

A corrupted pending or mask bit shows up as a wrong winner index on the next acknowledge. It can also show up as `int_out` staying low, about four clocks after the request edge. An enable that acknowledge fails to clear shows up as `int_out` still high on the clock after acknowledge.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          int_ack,
  output logic          int_out,
  output logic [DW-1:0] vec_out,
  output logic          vec_drive
);
  localparam int CW = $clog2(N);
  localparam int BW = DW - CW;

  logic [N-1:0]  s1, s2, prev, pend, mask;
  logic [N-1:0]  rise, clr, masked;
  logic [BW-1:0] base;
  logic [CW-1:0] code;
  logic          ien, ist;

  wire wr_mask = reg_we && reg_addr == 2'd0;
  wire wr_clr  = reg_we && reg_addr == 2'd1;
  wire wr_en   = reg_we && reg_addr == 2'd2;
  wire wr_base = reg_we && reg_addr == 2'd3;

  assign rise   = s2 & ~prev;
  assign clr    = wr_clr ? reg_wdata[N-1:0] : '0;
  assign masked = pend & mask;

  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--)
      if (masked[i]) code = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      pend <= '0;
      mask <= '0;
      base <= '0;
      ien  <= 1'b0;
      ist  <= 1'b0;
    end else begin
      s1   <= irq_in;
      s2   <= s1;
      prev <= s2;
      pend <= (pend & ~clr) | rise;
      ist  <= |masked;
      if (wr_mask) mask <= reg_wdata[N-1:0];
      if (wr_base) base <= reg_wdata[BW-1:0];
      if (int_ack)    ien <= 1'b0;
      else if (wr_en) ien <= reg_wdata[0];
    end
  end

  assign int_out   = ien & ist;
  assign vec_drive = int_ack;
  assign vec_out   = int_ack ? {base, code} : '0;

  // R2
  edge_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(rise)) == '0);

  // R3
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (pend & $past(pend)) == $past(pend));

  // R5
  lowest_index_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_drive && |masked) |-> (masked[code] && (masked & ((N'(1) << code) - N'(1))) == '0));

  // R6
  status_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist) |-> $past(|masked));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_out);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] irq_in = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic       int_ack = 0;
  logic       int_out, vec_drive;
  logic [7:0] vec_out;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_ack(int_ack),
    .int_out(int_out), .vec_out(vec_out), .vec_drive(vec_drive));

  function automatic logic [1:0] enc(input logic [3:0] m);
    for (int i = 3; i >= 0; i--) if (m[i]) enc = 2'(i);
    if (m == 0) enc = 0;
  endfunction

  function automatic logic [7:0] vecf(input logic [5:0] b, input logic [3:0] m);
    vecf = {b, enc(m)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse(input logic [3:0] b);
    irq_in = b; idle(2); irq_in = 0; idle(4);
  endtask

  task automatic ack_check(input string tag, input logic [7:0] exp_vec);
    int_ack = 1; #2;
    chk({tag, " R7 vec_drive"}, vec_drive, 1);
    chk({tag, " R5/R7 vector"}, vec_out, exp_vec);
    @(negedge clk); int_ack = 0; #1;
    chk({tag, " R8 int_out after ack"}, int_out, 0);
  endtask

  initial begin
    #(200000 * 20);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    // R1 reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 vec_drive", vec_drive, 0);
    chk("R1 vec_out", vec_out, 0);
    rst_n = 1; idle(1);
    wr(2, 1); idle(2);
    chk("R1 no pending", int_out, 0);
    int_ack = 1; #2;
    chk("R1 vector zero state", vec_out, 8'h00);
    @(negedge clk); int_ack = 0;

    // R4 masked source blocked
    wr(3, 8'h15);
    wr(2, 1);
    pulse(4'b0100);
    chk("R4 masked int_out", int_out, 0);
    wr(0, 8'h0F); idle(1);
    chk("R6 int_out after unmask", int_out, 1);
    ack_check("dir1", vecf(6'h15, 4'b0100));

    // R5 priority among several
    pulse(4'b1010);
    wr(2, 1); #1;
    chk("R6 int_out", int_out, 1);
    ack_check("R5 prio", vecf(6'h15, 4'b1110));

    // R3 clear one bit, others kept
    wr(1, 8'h02); idle(1);
    wr(2, 1);
    ack_check("R3 after clear", vecf(6'h15, 4'b1100));
    wr(1, 8'h00); idle(1); wr(2, 1);
    ack_check("R3 zero write", vecf(6'h15, 4'b1100));

    // R4 mask on the winner changes vector
    wr(0, 8'h08); idle(1); wr(2, 1);
    ack_check("R4 mask", vecf(6'h15, 4'b1000));
    wr(1, 8'h0F); wr(0, 8'h0F); idle(2); wr(2, 1); #1;
    chk("R3 all cleared", int_out, 0);

    // R2 held level does not re-set
    irq_in = 4'b0010; idle(6);
    chk("R2 captured", int_out, 1);
    wr(1, 8'h02); idle(3);
    chk("R2 held level no reset", int_out, 0);
    irq_in = 0; idle(3);

    // R9 set and clear same cycle
    irq_in = 4'b0001;
    idle(2);
    reg_we = 1; reg_addr = 1; reg_wdata = 8'h01;
    @(negedge clk); reg_we = 0; irq_in = 0; idle(3);
    chk("R9 set wins", int_out, 1);
    ack_check("R9", vecf(6'h15, 4'b0001));

    // R8 ack beats enable write
    wr(2, 1); #1;
    chk("R8 int_out before", int_out, 1);
    int_ack = 1; reg_we = 1; reg_addr = 2; reg_wdata = 1;
    @(negedge clk); int_ack = 0; reg_we = 0; #1;
    chk("R8 ack over write", int_out, 0);
    wr(1, 8'h0F); idle(2);

    // random
    for (int it = 0; it < 40; it++) begin
      logic [3:0] b, m;
      logic [5:0] bs;
      b = 4'($urandom); m = 4'($urandom); bs = 6'($urandom);
      wr(1, 8'h0F);
      wr(0, {4'h0, m});
      wr(3, {2'b0, bs});
      wr(2, 1);
      pulse(b);
      chk("R6 random int_out", int_out, |(b & m));
      if (|(b & m)) ack_check("R5 random", vecf(bs, b & m));
      else begin
        int_ack = 1; #2;
        chk("R4 random masked vec", vec_out, {bs, 2'b00});
        @(negedge clk); int_ack = 0; #1;
        chk("R7 released", vec_drive, 0);
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule